// File: doc/BRIEF.md
# Transmit Cell Fault Injector

This block sits in the transmit path of fixed-length 53-byte cells, between a UTOPIA-style transmit byte interface and the line encoder. It follows each accepted byte's position inside its cell. When its test controls ask for it, it damages a cell in a controlled way. It can invert the low bit of the header check byte, which is byte 5, or the low bit of the final payload byte, which is byte 53. Test equipment can then confirm that downstream switches, or the local receiver in loopback, detect and recover from such errors. Every byte passes through one register stage, whether it is changed or not.

The block also checks each transmit byte against an odd parity bit that arrives alongside it, and reports a mismatch on a one-cycle error pulse. A hold control can force the transmit cell-available indication low. This stops the upstream side from handing over cells, for example while the line is looped back.

Top module: `tx_cell_fault_inject`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid, out_soc and par_err are 0.
- R2: Each accepted input byte (in_valid=1) appears on out_data one clock later with out_valid=1. out_soc equals the in_soc of that byte. When no injection applies, the byte is unchanged. A cycle with in_valid=0 gives out_valid=0 on the following clock.
- R3: The byte that carries in_soc=1 is byte 1 of a cell. If inj_hec was 1 on that byte, then byte 5 of the cell leaves with bit 0 inverted, and all of its other bits are unchanged.
- R4: If inj_pay was 1 on the start-of-cell byte, then byte 53 of that cell leaves with bit 0 inverted. Bytes after the 53rd that arrive before the next start-of-cell pass unchanged.
- R5: When both inj_hec and inj_pay are 1 at start-of-cell, byte 5 and byte 53 of the same cell are both altered.
- R6: The injection controls are captured only on a start-of-cell byte. Changing them in the middle of a cell has no effect on that cell. The change applies from the next start-of-cell onward.
- R7: A start-of-cell byte restarts the count at 1, even when the previous cell was shorter than 53 bytes.
- R8: Idle cycles (in_valid=0) do not advance the byte count.
- R9: Bytes accepted after reset and before the first start-of-cell are never altered.
- R10: When par_chk_en is 1 on an accepted byte, and the XOR of in_data and in_par is 0 (odd parity expected), par_err is 1 on the following clock. In every other case par_err is 0 on that clock, including idle cycles and the case where checking is disabled.
- R11: tx_clav equals fifo_clav AND NOT clav_hold, combinationally. While clav_hold is 1, tx_clav is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input byte is valid this cycle |
| in_soc | input | 1 | Input byte is the first byte of a cell |
| in_data | input | 8 | Transmit byte from the cell interface |
| in_par | input | 1 | Odd parity bit for in_data |
| inj_hec | input | 1 | Request an inverted bit 0 on the header check byte |
| inj_pay | input | 1 | Request an inverted bit 0 on the last payload byte |
| par_chk_en | input | 1 | Enable the odd parity check |
| clav_hold | input | 1 | Force the cell-available output low |
| fifo_clav | input | 1 | Cell-available from the transmit buffer |
| tx_clav | output | 1 | Gated cell-available toward the upstream side |
| out_valid | output | 1 | Output byte valid |
| out_soc | output | 1 | Output byte is the first byte of a cell |
| out_data | output | 8 | Byte toward the line encoder |
| par_err | output | 1 | One-cycle pulse on a parity mismatch |

## Verification
The assertions assume that in_valid, in_soc and the control inputs change only between clock edges. They also assume in_soc is meaningful only when in_valid is 1, and that reset is released in step with the clock. The bench drives all inputs on the falling edge, so every value is stable at the sampling edge. It raises in_soc only together with in_valid. It holds all inputs idle while reset is applied and for several cycles after release. Cell lengths include short, exact and over-long cells, and idle gaps appear inside cells. This lets the reference model reach every count boundary without the assumptions ever being broken.

// File: rtl/tcfi_pkg.sv
package tcfi_pkg;
  // flip request for the byte currently on the input
  typedef struct packed {
    logic hec;
    logic pay;
  } tcfi_flip_t;
endpackage

// File: rtl/tcfi_pos_track.sv
module tcfi_pos_track #(
  parameter int CELL_BYTES = 53,
  parameter int HEC_IDX    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_en,
  input  logic soc,
  output logic at_hec,
  output logic at_last
);
  localparam int POS_W = $clog2(CELL_BYTES + 1);
  localparam logic [POS_W-1:0] POS_ONE  = POS_W'(1);
  localparam logic [POS_W-1:0] POS_SAT  = POS_W'(CELL_BYTES);
  localparam logic [POS_W-1:0] POS_LM1  = POS_W'(CELL_BYTES - 1);
  localparam logic [POS_W-1:0] POS_HM1  = POS_W'(HEC_IDX - 1);

  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (byte_en) begin
      if (soc)
        pos_d = POS_ONE;
      else if (pos_q != POS_SAT)
        pos_d = pos_q + POS_ONE;
    end
  end

  // reset to saturated: no cell open until the first start-of-cell
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos_q <= POS_SAT;
    else if (byte_en)
      pos_q <= pos_d;
  end

  generate
    if (HEC_IDX == 1) begin : g_hec_first
      assign at_hec = byte_en && soc;
    end else begin : g_hec_later
      assign at_hec = byte_en && !soc && (pos_q == POS_HM1);
    end
  endgenerate

  assign at_last = byte_en && !soc && (pos_q == POS_LM1);
endmodule

// File: rtl/tcfi_flip_gen.sv
module tcfi_flip_gen
  import tcfi_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FLIP_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_en,
  input  logic              soc,
  input  logic              req_hec,
  input  logic              req_pay,
  input  logic              at_hec,
  input  logic              at_last,
  output logic [DATA_W-1:0] flip_mask
);
  tcfi_flip_t arm_q, arm_d, arm_eff;
  logic       hit;

  always_comb begin
    arm_d = arm_q;
    if (byte_en && soc) begin
      arm_d.hec = req_hec;
      arm_d.pay = req_pay;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      arm_q <= '0;
    else if (byte_en && soc)
      arm_q <= arm_d;
  end

  // the start-of-cell byte itself already uses the freshly captured request
  assign arm_eff = (byte_en && soc) ? arm_d : arm_q;
  assign hit     = (arm_eff.hec && at_hec) || (arm_eff.pay && at_last);

  always_comb begin
    flip_mask           = '0;
    flip_mask[FLIP_BIT] = hit;
  end
endmodule

// File: rtl/tcfi_odd_par.sv
module tcfi_odd_par #(
  parameter int DATA_W = 8
) (
  input  logic              byte_en,
  input  logic              chk_en,
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  output logic              mismatch
);
  logic ones_odd;
  assign ones_odd = ^{data, par};
  assign mismatch = byte_en && chk_en && !ones_odd;
endmodule

// File: rtl/tx_cell_fault_inject.sv
module tx_cell_fault_inject
  import tcfi_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter int HEC_IDX    = 5,
  parameter int FLIP_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_soc,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_par,
  input  logic              inj_hec,
  input  logic              inj_pay,
  input  logic              par_chk_en,
  input  logic              clav_hold,
  input  logic              fifo_clav,
  output logic              tx_clav,
  output logic              out_valid,
  output logic              out_soc,
  output logic [DATA_W-1:0] out_data,
  output logic              par_err
);
  logic              at_hec, at_last, par_bad;
  logic [DATA_W-1:0] flip_mask;
  logic [DATA_W-1:0] data_d;
  logic              valid_q, soc_q, perr_q;
  logic [DATA_W-1:0] data_q;

  tcfi_pos_track #(
    .CELL_BYTES(CELL_BYTES),
    .HEC_IDX   (HEC_IDX)
  ) u_pos (
    .clk    (clk),
    .rst_n  (rst_n),
    .byte_en(in_valid),
    .soc    (in_soc),
    .at_hec (at_hec),
    .at_last(at_last)
  );

  tcfi_flip_gen #(
    .DATA_W  (DATA_W),
    .FLIP_BIT(FLIP_BIT)
  ) u_flip (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_en  (in_valid),
    .soc      (in_soc),
    .req_hec  (inj_hec),
    .req_pay  (inj_pay),
    .at_hec   (at_hec),
    .at_last  (at_last),
    .flip_mask(flip_mask)
  );

  tcfi_odd_par #(
    .DATA_W(DATA_W)
  ) u_par (
    .byte_en (in_valid),
    .chk_en  (par_chk_en),
    .data    (in_data),
    .par     (in_par),
    .mismatch(par_bad)
  );

  assign data_d = in_data ^ flip_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      soc_q   <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      valid_q <= in_valid;
      soc_q   <= in_valid && in_soc;
      perr_q  <= par_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (in_valid)
      data_q <= data_d;
  end

  assign out_valid = valid_q;
  assign out_soc   = soc_q;
  assign out_data  = data_q;
  assign par_err   = perr_q;
  assign tx_clav   = fifo_clav && !clav_hold;
endmodule

// File: rtl/tcfi_checker.sv
module tcfi_checker #(
  parameter int DATA_W   = 8,
  parameter int FLIP_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_soc,
  input logic [DATA_W-1:0] in_data,
  input logic              in_par,
  input logic              par_chk_en,
  input logic              clav_hold,
  input logic              tx_clav,
  input logic              out_valid,
  input logic              out_soc,
  input logic [DATA_W-1:0] out_data,
  input logic              par_err
);
  localparam logic [DATA_W-1:0] KEEP = ~(DATA_W'(1) << FLIP_BIT);

  // R11: hold forces cell-available low
  a_r11_clav_hold: assert property (@(posedge clk) disable iff (!rst_n)
    clav_hold |-> !tx_clav);

  // R2: valid follows one cycle later
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_soc_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_soc) |=> out_soc);

  // R3: injection never touches any bit other than the chosen one
  a_r3_only_flip_bit: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_data ^ $past(in_data)) & KEEP) == '0);
  a_r3_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $countones(out_data ^ $past(in_data)) <= 1);

  // R10: no error pulse without an enabled, accepted byte
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || !par_chk_en) |=> !par_err);
  a_r10_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && par_chk_en && !(^{in_data, in_par})) |=> par_err);
endmodule

bind tx_cell_fault_inject tcfi_checker #(
  .DATA_W  (DATA_W),
  .FLIP_BIT(FLIP_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_soc    (in_soc),
  .in_data   (in_data),
  .in_par    (in_par),
  .par_chk_en(par_chk_en),
  .clav_hold (clav_hold),
  .tx_clav   (tx_clav),
  .out_valid (out_valid),
  .out_soc   (out_soc),
  .out_data  (out_data),
  .par_err   (par_err)
);

// File: tb/tx_cell_fault_inject_bench.sv
module tx_cell_fault_inject_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_soc, in_par;
  logic [7:0] in_data;
  logic       inj_hec, inj_pay, par_chk_en, clav_hold, fifo_clav;
  logic       tx_clav, out_valid, out_soc, par_err;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  tx_cell_fault_inject u_tx_cell_fault_inject (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_soc(in_soc), .in_data(in_data), .in_par(in_par),
    .inj_hec(inj_hec), .inj_pay(inj_pay), .par_chk_en(par_chk_en),
    .clav_hold(clav_hold), .fifo_clav(fifo_clav), .tx_clav(tx_clav),
    .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data), .par_err(par_err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  string cur_req = "R2";

  // requested controls, applied at the next falling edge with the inputs
  logic w_hec = 0, w_pay = 0, w_par_en = 0, w_hold = 0, w_fclav = 0;

  // reference model state
  int  m_pos = 0;          // 0: no cell opened yet
  bit  m_hec = 0, m_pay = 0;
  bit  e_valid = 0, e_soc = 0, e_perr = 0;
  logic [7:0] e_data = 0;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit v, bit s, logic [7:0] d, bit p);
    bit flip;
    @(negedge clk);
    check(cur_req, {7'd0, out_valid}, {7'd0, e_valid});
    check(cur_req, {7'd0, out_soc}, {7'd0, e_soc});
    if (e_valid) check(cur_req, out_data, e_data);
    check("R10", {7'd0, par_err}, {7'd0, e_perr});
    inj_hec = w_hec; inj_pay = w_pay; par_chk_en = w_par_en;
    clav_hold = w_hold; fifo_clav = w_fclav;
    in_valid = v; in_soc = s; in_data = d; in_par = p;
    flip = 0;
    if (v) begin
      if (s) begin
        m_pos = 1; m_hec = w_hec; m_pay = w_pay;
      end else if (m_pos > 0 && m_pos < 54) begin
        m_pos++;
      end
      flip = (m_hec && m_pos == 5) || (m_pay && m_pos == 53);
    end
    e_valid = v;
    e_soc   = v && s;
    if (v) e_data = d ^ {7'd0, flip};
    e_perr  = v && w_par_en && ((^d ^ p) == 1'b0);
    #1;
    check("R11", {7'd0, tx_clav}, {7'd0, w_fclav && !w_hold});
  endtask

  function automatic bit odd_par(logic [7:0] d);
    return ~(^d);
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 1'b0);
  endtask

  // send a cell; at byte chg_at (0 = never) the injection requests change
  task automatic send_cell(int len, bit gaps, int chg_at, bit nh, bit np);
    for (int i = 1; i <= len; i++) begin
      logic [7:0] d;
      if (i == chg_at) begin w_hec = nh; w_pay = np; end
      d = 8'($urandom);
      step(1, i == 1, d, odd_par(d));
      if (gaps && ($urandom % 4 == 0)) idle(1 + $urandom % 2);
    end
  endtask

  initial begin
    rst_n = 0;
    in_valid = 0; in_soc = 0; in_data = 0; in_par = 0;
    inj_hec = 0; inj_pay = 0; par_chk_en = 0; clav_hold = 0; fifo_clav = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {5'd0, out_valid, out_soc, par_err}, 8'h00);
    @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    idle(3);

    // R9: bytes before any start-of-cell, with injection requested
    cur_req = "R9"; w_hec = 1; w_pay = 1;
    for (int i = 0; i < 60; i++) begin
      logic [7:0] d = 8'($urandom);
      step(1, 0, d, odd_par(d));
    end

    // R2: plain cell
    cur_req = "R2"; w_hec = 0; w_pay = 0;
    send_cell(53, 0, 0, 0, 0);
    idle(2);
    // R3: header check byte
    cur_req = "R3"; w_hec = 1;
    send_cell(53, 0, 0, 1, 0);
    // R4: last payload byte, over-long cell
    cur_req = "R4"; w_hec = 0; w_pay = 1;
    send_cell(58, 0, 0, 0, 1);
    // R5: both on one cell
    cur_req = "R5"; w_hec = 1; w_pay = 1;
    send_cell(53, 0, 0, 1, 1);
    // R6: change mid-cell, then a cell that uses the new setting
    cur_req = "R6"; w_hec = 0; w_pay = 0;
    send_cell(53, 0, 2, 1, 1);
    send_cell(53, 0, 10, 0, 0);
    send_cell(53, 0, 0, 0, 0);
    // R7: short cells restart the count
    cur_req = "R7"; w_hec = 1; w_pay = 1;
    send_cell(3, 0, 0, 1, 1);
    send_cell(7, 0, 0, 1, 1);
    send_cell(53, 0, 0, 1, 1);
    // R8: idle gaps inside cells
    cur_req = "R8";
    for (int c = 0; c < 4; c++) send_cell(53, 1, 0, 1, 1);

    // R10: parity checking, good and bad, enabled and disabled, idle
    cur_req = "R10"; w_hec = 0; w_pay = 0;
    for (int i = 0; i < 80; i++) begin
      logic [7:0] d = 8'($urandom);
      bit bad = ($urandom % 3 == 0);
      w_par_en = (i % 20) < 14;
      step(($urandom % 5) != 0, 0, d, odd_par(d) ^ bad);
    end
    w_par_en = 0;

    // R11: cell-available gating
    cur_req = "R11";
    for (int i = 0; i < 16; i++) begin
      w_fclav = i[0]; w_hold = i[1];
      step(0, 0, 8'h00, 1'b0);
    end
    w_hold = 0; w_fclav = 0;
    idle(2);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule